// File: doc/BRIEF.md
# Two-Level Round-Robin Switch Arbiter

This block decides which of N requesters may drive a single output port of a switch. Rather than one wide round-robin search, it is organised as a shallow tree. Leaf nodes each serve a group of four requesters. A root node chooses among the groups.

Every leaf sends the OR of its group's requests up to the root. The root picks one group with its own rotating priority pointer and sends a select back down to that leaf. The selected leaf then grants one requester, using its own pointer. The grant is combinational from the requests and the stored pointers.

When the transfer-done acknowledge arrives, only the nodes on the granted path move their pointers. The root pointer moves one past the winning group, and that group's leaf pointer moves one past the winning requester. The parameter `N_REQ` selects one of three builds:
- 4: a single four-way root.
- 8: a two-way root over two four-way leaves.
- 16: a four-way root over four four-way leaves.

Top module: `tree_rr_arbiter`

## Requirements
- R1: After reset every pointer is 0, so with all requests high the grant is bit 0.
- R2: The grant has at most one bit set; it is all zero exactly when no request is high.
- R3: A grant bit is set only for a requester whose request is high.
- R4: Requester i belongs to group i/4 at local position i%4. Within the chosen group, priority starts at the leaf pointer and proceeds upward in position, wrapping from 3 to 0.
- R5: The root picks a group starting at the root pointer and proceeding upward, wrapping around. Only one leaf is selected in any cycle.
- R6: A group's summary request is the OR of its four requests, so a group with no request high is skipped by the root.
- R7: On a cycle with the acknowledge high and a grant issued, the root pointer becomes one past the winning group. The winning group's leaf pointer becomes one past the winning local position. All other leaf pointers hold.
- R8: The acknowledge has no effect on any pointer when no request is high.
- R9: With N_REQ=16 and all requests held high from reset, the k-th grant (counting from 0) goes to requester (k%4)*4 + (k/4)%4, so each requester is served once in every 16 acknowledges.
- R10: With N_REQ=8 and all requests held high from reset, the k-th grant goes to requester (k%2)*4 + (k/2)%4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_REQ | Request vector, one bit per requester |
| xfer_ack_i | input | 1 | Transfer done; advances pointers on the granted path |
| grant_o | output | N_REQ | One-hot grant |

## Verification
The hardest state to reach from the ports has the root pointer and several leaf pointers at different nonzero positions at the same time. Only then can a wrong choice of which leaf advances be seen. The stimulus reaches this state with narrow request patterns confined to one or two groups, acknowledging selected grants, and then presenting patterns that expose each pointer separately. A leaf that was never acknowledged must still favour position 0. A long run under full load then checks the interleaved service order for both the 16-way and 8-way builds.

// File: rtl/tree_arb_pkg.sv
package tree_arb_pkg;
    localparam int unsigned MAX_W = 4;
    localparam int unsigned LEAF_W = 4;

    typedef struct packed {
        logic [1:0] ptr;
    } node_st_t;

    function automatic logic [1:0] ptr_after(input logic [1:0] win, input int unsigned w);
        logic [1:0] r;
        if (win == 2'(w - 1)) r = 2'd0;
        else                  r = win + 2'd1;
        return r;
    endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] req_i,
    input  logic [1:0]   ptr_i,
    output logic [W-1:0] gnt_o,
    output logic [1:0]   win_o
);
    import tree_arb_pkg::*;

    logic [MAX_W-1:0] r4;
    logic [MAX_W-1:0] g4;
    logic [1:0]       idx;
    logic             found;

    always_comb begin
        r4    = MAX_W'(req_i);
        g4    = '0;
        win_o = '0;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < int'(W); k++) begin
            idx = 2'((int'(ptr_i) + k) % int'(W));
            if (!found && r4[idx]) begin
                g4[idx] = 1'b1;
                win_o   = idx;
                found   = 1'b1;
            end
        end
    end

    assign gnt_o = g4[W-1:0];

    always_comb begin
        if (!$isunknown(req_i)) begin
            a_pick_onehot_r2: assert ($onehot0(gnt_o));
            a_pick_subset_r3: assert ((gnt_o & ~req_i) == '0);
        end
    end
endmodule

// File: rtl/rr_leaf_node.sv
module rr_leaf_node #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_i,
    input  logic         sel_i,
    input  logic         xfer_ack_i,
    output logic         sum_o,
    output logic [W-1:0] grant_o
);
    import tree_arb_pkg::*;

    node_st_t      st_d, st_q;
    logic [W-1:0]  pick_gnt;
    logic [1:0]    pick_win;
    logic          adv;

    rr_pick #(.W(W)) u_pick (
        .req_i (req_i),
        .ptr_i (st_q.ptr),
        .gnt_o (pick_gnt),
        .win_o (pick_win)
    );

    assign sum_o   = |req_i;
    assign grant_o = sel_i ? pick_gnt : '0;
    assign adv     = xfer_ack_i && sel_i && sum_o;

    always_comb begin
        st_d = st_q;
        if (adv) st_d.ptr = ptr_after(pick_win, W);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_leaf_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |-> grant_o == '0);
    p_leaf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.ptr));
    p_leaf_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ((st_q.ptr == 2'd0) ? 2'(W - 1) : st_q.ptr - 2'd1) == $past(pick_win));
endmodule

// File: rtl/rr_root_node.sv
module rr_root_node #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] child_req_i,
    input  logic         xfer_ack_i,
    output logic [W-1:0] child_sel_o
);
    import tree_arb_pkg::*;

    node_st_t     st_d, st_q;
    logic [1:0]   pick_win;
    logic         adv;

    rr_pick #(.W(W)) u_pick (
        .req_i (child_req_i),
        .ptr_i (st_q.ptr),
        .gnt_o (child_sel_o),
        .win_o (pick_win)
    );

    assign adv = xfer_ack_i && (|child_req_i);

    always_comb begin
        st_d = st_q;
        if (adv) st_d.ptr = ptr_after(pick_win, W);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_root_onesel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(child_sel_o));
    p_root_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q.ptr));
    p_root_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|child_req_i) |-> (|child_sel_o));
endmodule

// File: rtl/tree_rr_arbiter.sv
module tree_rr_arbiter #(
    parameter int unsigned N_REQ = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic             xfer_ack_i,
    output logic [N_REQ-1:0] grant_o
);
    import tree_arb_pkg::*;

    localparam int unsigned N_GRP = (N_REQ > LEAF_W) ? N_REQ / LEAF_W : 1;

    generate
        if (N_REQ <= LEAF_W) begin : g_flat
            rr_root_node #(.W(N_REQ)) u_root (
                .clk         (clk),
                .rst_n       (rst_n),
                .child_req_i (req_i),
                .xfer_ack_i  (xfer_ack_i),
                .child_sel_o (grant_o)
            );
        end else begin : g_tree
            logic [N_GRP-1:0] grp_sum;
            logic [N_GRP-1:0] grp_sel;

            rr_root_node #(.W(N_GRP)) u_root (
                .clk         (clk),
                .rst_n       (rst_n),
                .child_req_i (grp_sum),
                .xfer_ack_i  (xfer_ack_i),
                .child_sel_o (grp_sel)
            );

            for (genvar g = 0; g < int'(N_GRP); g++) begin : g_leaf
                rr_leaf_node #(.W(LEAF_W)) u_leaf (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .req_i      (req_i[g*LEAF_W +: LEAF_W]),
                    .sel_i      (grp_sel[g]),
                    .xfer_ack_i (xfer_ack_i),
                    .sum_o      (grp_sum[g]),
                    .grant_o    (grant_o[g*LEAF_W +: LEAF_W])
                );
            end
        end
    endgenerate

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    p_nonidle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> (|grant_o));
    p_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);
endmodule

// File: tb/sim_tree_rr_arbiter.sv
`timescale 1ns/1ps
module sim_tree_rr_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req16 = '0;
    logic        ack16 = 1'b0;
    logic [15:0] gnt16;
    logic [7:0]  req8 = '0;
    logic        ack8 = 1'b0;
    logic [7:0]  gnt8;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    always #2.5 clk = ~clk;

    tree_rr_arbiter #(.N_REQ(16)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req16), .xfer_ack_i(ack16), .grant_o(gnt16));
    tree_rr_arbiter #(.N_REQ(8)) u8 (
        .clk(clk), .rst_n(rst_n), .req_i(req8), .xfer_ack_i(ack8), .grant_o(gnt8));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] r, input logic a, input logic [7:0] r8, input logic a8);
        @(negedge clk);
        req16 = r; ack16 = a; req8 = r8; ack8 = a8;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req16 = '0; ack16 = 1'b0; req8 = '0; ack8 = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        drive(16'hFFFF, 1'b0, 8'hFF, 1'b0);
        chk("R1 reset grant 16", gnt16, 16'h0001);
        chk("R1 reset grant 8", {8'h00, gnt8}, 16'h0001);
    endtask

    task automatic t_idle_ack();
        do_reset();
        drive(16'h0000, 1'b0, 8'h00, 1'b0);
        chk("R2 no request no grant", gnt16, 16'h0000);
        drive(16'h0000, 1'b1, 8'h00, 1'b1);
        drive(16'h0000, 1'b1, 8'h00, 1'b1);
        drive(16'hFFFF, 1'b0, 8'hFF, 1'b0);
        chk("R8 idle ack leaves pointers", gnt16, 16'h0001);
        chk("R8 idle ack leaves pointers 8", {8'h00, gnt8}, 16'h0001);
    endtask

    task automatic t_single();
        do_reset();
        for (int i = 0; i < 16; i++) begin
            drive(16'(1 << i), 1'b0, 8'h00, 1'b0);
            chk("R3 single requester", gnt16, 16'(1 << i));
        end
    endtask

    task automatic t_leaf_wrap();
        do_reset();
        drive(16'h0006, 1'b1, 8'h00, 1'b0);
        chk("R4 leaf first from pointer 0", gnt16, 16'h0002);
        drive(16'h0006, 1'b1, 8'h00, 1'b0);
        chk("R4 leaf after advance", gnt16, 16'h0004);
        drive(16'h0006, 1'b0, 8'h00, 1'b0);
        chk("R4 leaf wraps past 3", gnt16, 16'h0002);
    endtask

    task automatic t_root_order();
        do_reset();
        drive(16'h4200, 1'b0, 8'h00, 1'b0);
        chk("R6 empty groups skipped", gnt16, 16'h0200);
        drive(16'h2020, 1'b1, 8'h00, 1'b0);
        chk("R5 root from pointer 0", gnt16, 16'h0020);
        drive(16'h2021, 1'b0, 8'h00, 1'b0);
        chk("R5 root pointer moved past group 1", gnt16, 16'h2000);
        drive(16'h0060, 1'b0, 8'h00, 1'b0);
        chk("R7 winning leaf advanced", gnt16, 16'h0040);
        drive(16'h0006, 1'b0, 8'h00, 1'b0);
        chk("R7 other leaf held", gnt16, 16'h0002);
        drive(16'h0600, 1'b0, 8'h00, 1'b0);
        chk("R7 other leaf held 2", gnt16, 16'h0200);
    endtask

    task automatic t_full_load();
        int served[16];
        int exp16;
        int exp8;
        do_reset();
        for (int i = 0; i < 16; i++) served[i] = 0;
        for (int k = 0; k < 32; k++) begin
            exp16 = (k % 4) * 4 + (k / 4) % 4;
            exp8  = (k % 2) * 4 + (k / 2) % 4;
            drive(16'hFFFF, 1'b1, 8'hFF, 1'b1);
            chk("R9 full load order", gnt16, 16'(1 << exp16));
            chk("R10 eight-way order", {8'h00, gnt8}, 16'(1 << exp8));
            for (int i = 0; i < 16; i++) if (gnt16[i]) served[i]++;
        end
        for (int i = 0; i < 16; i++)
            chk("R9 served twice in 32", 16'(served[i]), 16'd2);
        drive(16'h0000, 1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        t_reset_state();
        t_idle_ack();
        t_single();
        t_leaf_wrap();
        t_root_order();
        t_full_load();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule